// File: doc/BRIEF.md
# Running-Priority Register Read Trap Decoder

This block decides, without any clock, what must happen when software tries to read the running-priority system register of the interrupt controller. It takes the five fields of the system-instruction encoding, the current exception level, and a small set of configuration bits. It returns exactly one of six outcomes: the access is undefined, the access traps to EL1, EL2 or EL3, the read is redirected to the virtual copy of the register, or the read returns the physical register.

The configuration bits are as follows:
- one system-register-enable bit per privileged level;
- the hypervisor's common trap bit and its FIQ and IRQ route bits;
- the secure monitor's IRQ and FIQ route bits;
- flags that say whether EL2 is enabled and runs in 64-bit state, and whether EL3 is present and runs in 64-bit state.

A trap outcome also carries the exception syndrome class. An encoding that names a different register produces no outcome and raises a no-match flag. The block does not perform the read and does not take the exception. It only resolves the fixed-priority chain that the pipeline acts on.

Top module: `sysreg_rdprio_trap_dec`

## Requirements
- R1: The encoding matches only when op0=3, op1=0, CRn=12, CRm=11 and op2=3. Any other encoding drives `no_match`=1, `outcome`=0 and `trap_class`=0.
- R2: For a matching encoding, `no_match`=0 and exactly one bit of `outcome` is set. The bit positions are: 0 undefined, 1 trap to EL1, 2 trap to EL2, 3 trap to EL3, 4 virtual register, 5 physical register.
- R3: At `cur_el`=0 a matching read is undefined (bit 0).
- R4: At `cur_el`=1 the first rule that applies decides the outcome, in this order:
  - `sysreg_en_el1`=0 gives trap to EL1;
  - otherwise, "EL2 live" (`el2_enabled`=1 and `el2_is64`=1) with `hyp_trap_common`=1 gives trap to EL2;
  - otherwise, "EL2 live" with either hypervisor route bit set gives the virtual register;
  - otherwise, the monitor block condition of R8 gives trap to EL3;
  - otherwise, the physical register.
- R5: A hypervisor FIQ or IRQ route bit redirects an EL1 read to the virtual register only when EL2 is live. Without that, the bits have no effect.
- R6: At `cur_el`=2, `sysreg_en_el2`=0 gives trap to EL2. Otherwise the monitor block condition gives trap to EL3. Otherwise the read returns the physical register.
- R7: At `cur_el`=3, `sysreg_en_el3`=0 gives trap to EL3. Otherwise the read returns the physical register.
- R8: The monitor block condition requires all four of these: `el3_present`, `el3_is64`, `mon_irq_route` and `mon_fiq_route`. Either route bit alone never produces a trap to EL3.
- R9: `trap_class` is 0x18 whenever a trap outcome (bit 1, 2 or 3) is set, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_op0 | input | 2 | op0 field of the access encoding |
| enc_op1 | input | 3 | op1 field |
| enc_crn | input | 4 | CRn field |
| enc_crm | input | 4 | CRm field |
| enc_op2 | input | 3 | op2 field |
| cur_el | input | 2 | Current exception level, 0 to 3 |
| sysreg_en_el1 | input | 1 | System-register interface enable at EL1 |
| sysreg_en_el2 | input | 1 | System-register interface enable at EL2 |
| sysreg_en_el3 | input | 1 | System-register interface enable at EL3 |
| el2_enabled | input | 1 | EL2 is implemented and enabled |
| el2_is64 | input | 1 | EL2 runs in 64-bit state |
| el3_present | input | 1 | EL3 is implemented |
| el3_is64 | input | 1 | EL3 runs in 64-bit state |
| hyp_trap_common | input | 1 | Hypervisor common interrupt-register trap |
| hyp_fiq_route | input | 1 | Hypervisor routes FIQs to itself |
| hyp_irq_route | input | 1 | Hypervisor routes IRQs to itself |
| mon_irq_route | input | 1 | Secure monitor routes IRQs to EL3 |
| mon_fiq_route | input | 1 | Secure monitor routes FIQs to EL3 |
| outcome | output | 6 | One-hot access outcome, bit order as in R2 |
| no_match | output | 1 | Encoding names another register |
| trap_class | output | 6 | Syndrome class for a trap, else 0 |

## Verification
The checks assume that the inputs are settled, two-state values when they are sampled. They also assume that `cur_el` always names one of the four levels, which its 2-bit width guarantees. The stimulus changes inputs only just after a rising bench edge and samples on the falling edge, so no check sees a half-updated input set. The sweep drives all 4096 configuration combinations at every level with the matching encoding. Flipping each encoding bit in turn, plus a few near-miss field values, exercises the no-match path under a fully enabled configuration.

// File: rtl/rdprio_pkg.sv
package rdprio_pkg;

  typedef enum int unsigned {
    OC_UNDEF = 0,
    OC_TRAP1 = 1,
    OC_TRAP2 = 2,
    OC_TRAP3 = 3,
    OC_VIRT  = 4,
    OC_PHYS  = 5
  } outcome_idx_e;

  localparam int unsigned OC_N = 6;

  // Outcome positions that represent a trap and so carry a syndrome class.
  localparam logic [OC_N-1:0] OC_TRAP_MASK = 6'b001110;

endpackage

// File: rtl/rdprio_enc_match.sv
module rdprio_enc_match #(
  parameter int unsigned OP0_W = 2,
  parameter int unsigned OP1_W = 3,
  parameter int unsigned CRN_W = 4,
  parameter int unsigned CRM_W = 4,
  parameter int unsigned OP2_W = 3,
  parameter logic [OP0_W-1:0] OP0_VAL = 2'b11,
  parameter logic [OP1_W-1:0] OP1_VAL = 3'b000,
  parameter logic [CRN_W-1:0] CRN_VAL = 4'b1100,
  parameter logic [CRM_W-1:0] CRM_VAL = 4'b1011,
  parameter logic [OP2_W-1:0] OP2_VAL = 3'b011
) (
  input  logic [OP0_W-1:0] op0,
  input  logic [OP1_W-1:0] op1,
  input  logic [CRN_W-1:0] crn,
  input  logic [CRM_W-1:0] crm,
  input  logic [OP2_W-1:0] op2,
  output logic             hit
);

  localparam int unsigned FIELDS = 5;

  logic [FIELDS-1:0] field_eq;

  always_comb begin
    field_eq[0] = (op0 == OP0_VAL);
    field_eq[1] = (op1 == OP1_VAL);
    field_eq[2] = (crn == CRN_VAL);
    field_eq[3] = (crm == CRM_VAL);
    field_eq[4] = (op2 == OP2_VAL);
  end

  assign hit = &field_eq;

endmodule

// File: rtl/rdprio_level_chain.sv
module rdprio_level_chain
  import rdprio_pkg::*;
#(
  parameter int unsigned EL_W = 2
) (
  input  logic [EL_W-1:0] cur_el,
  input  logic            sysreg_en_el1,
  input  logic            sysreg_en_el2,
  input  logic            sysreg_en_el3,
  input  logic            el2_enabled,
  input  logic            el2_is64,
  input  logic            el3_present,
  input  logic            el3_is64,
  input  logic            hyp_trap_common,
  input  logic            hyp_fiq_route,
  input  logic            hyp_irq_route,
  input  logic            mon_irq_route,
  input  logic            mon_fiq_route,
  output logic [OC_N-1:0] verdict
);

  logic el2_live;
  logic mon_block;
  logic hyp_redirect;

  always_comb begin
    el2_live     = el2_enabled & el2_is64;
    mon_block    = el3_present & el3_is64 & mon_irq_route & mon_fiq_route;
    hyp_redirect = el2_live & (hyp_fiq_route | hyp_irq_route);
  end

  // Fixed-priority resolution per level; the first matching rule wins.
  always_comb begin
    verdict = '0;
    case (cur_el)
      EL_W'(0): verdict[OC_UNDEF] = 1'b1;
      EL_W'(1): begin
        if (!sysreg_en_el1)                verdict[OC_TRAP1] = 1'b1;
        else if (el2_live & hyp_trap_common) verdict[OC_TRAP2] = 1'b1;
        else if (hyp_redirect)             verdict[OC_VIRT]  = 1'b1;
        else if (mon_block)                verdict[OC_TRAP3] = 1'b1;
        else                               verdict[OC_PHYS]  = 1'b1;
      end
      EL_W'(2): begin
        if (!sysreg_en_el2)                verdict[OC_TRAP2] = 1'b1;
        else if (mon_block)                verdict[OC_TRAP3] = 1'b1;
        else                               verdict[OC_PHYS]  = 1'b1;
      end
      default: begin
        if (!sysreg_en_el3)                verdict[OC_TRAP3] = 1'b1;
        else                               verdict[OC_PHYS]  = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/rdprio_verdict_pack.sv
module rdprio_verdict_pack
  import rdprio_pkg::*;
#(
  parameter int unsigned          CLASS_W   = 6,
  parameter logic [CLASS_W-1:0]   CLASS_VAL = 6'h18
) (
  input  logic               hit,
  input  logic [OC_N-1:0]    verdict,
  output logic [OC_N-1:0]    outcome,
  output logic               no_match,
  output logic [CLASS_W-1:0] trap_class
);

  logic [OC_N-1:0] trap_bits;

  for (genvar gi = 0; gi < OC_N; gi++) begin : g_gate
    assign outcome[gi] = hit & verdict[gi];
    if (OC_TRAP_MASK[gi]) begin : g_trap
      assign trap_bits[gi] = hit & verdict[gi];
    end else begin : g_plain
      assign trap_bits[gi] = 1'b0;
    end
  end

  assign no_match   = ~hit;
  assign trap_class = (|trap_bits) ? CLASS_VAL : '0;

endmodule

// File: rtl/sysreg_rdprio_trap_dec.sv
module sysreg_rdprio_trap_dec
  import rdprio_pkg::*;
#(
  parameter int unsigned        OP0_W     = 2,
  parameter int unsigned        OP1_W     = 3,
  parameter int unsigned        CRN_W     = 4,
  parameter int unsigned        CRM_W     = 4,
  parameter int unsigned        OP2_W     = 3,
  parameter int unsigned        EL_W      = 2,
  parameter int unsigned        CLASS_W   = 6,
  parameter logic [CLASS_W-1:0] CLASS_VAL = 6'h18
) (
  input  logic [OP0_W-1:0]   enc_op0,
  input  logic [OP1_W-1:0]   enc_op1,
  input  logic [CRN_W-1:0]   enc_crn,
  input  logic [CRM_W-1:0]   enc_crm,
  input  logic [OP2_W-1:0]   enc_op2,
  input  logic [EL_W-1:0]    cur_el,
  input  logic               sysreg_en_el1,
  input  logic               sysreg_en_el2,
  input  logic               sysreg_en_el3,
  input  logic               el2_enabled,
  input  logic               el2_is64,
  input  logic               el3_present,
  input  logic               el3_is64,
  input  logic               hyp_trap_common,
  input  logic               hyp_fiq_route,
  input  logic               hyp_irq_route,
  input  logic               mon_irq_route,
  input  logic               mon_fiq_route,
  output logic [OC_N-1:0]    outcome,
  output logic               no_match,
  output logic [CLASS_W-1:0] trap_class
);

  logic            enc_hit;
  logic [OC_N-1:0] level_verdict;

  rdprio_enc_match #(
    .OP0_W(OP0_W), .OP1_W(OP1_W), .CRN_W(CRN_W), .CRM_W(CRM_W), .OP2_W(OP2_W)
  ) u_match (
    .op0(enc_op0), .op1(enc_op1), .crn(enc_crn), .crm(enc_crm), .op2(enc_op2),
    .hit(enc_hit)
  );

  rdprio_level_chain #(.EL_W(EL_W)) u_chain (
    .cur_el          (cur_el),
    .sysreg_en_el1   (sysreg_en_el1),
    .sysreg_en_el2   (sysreg_en_el2),
    .sysreg_en_el3   (sysreg_en_el3),
    .el2_enabled     (el2_enabled),
    .el2_is64        (el2_is64),
    .el3_present     (el3_present),
    .el3_is64        (el3_is64),
    .hyp_trap_common (hyp_trap_common),
    .hyp_fiq_route   (hyp_fiq_route),
    .hyp_irq_route   (hyp_irq_route),
    .mon_irq_route   (mon_irq_route),
    .mon_fiq_route   (mon_fiq_route),
    .verdict         (level_verdict)
  );

  rdprio_verdict_pack #(.CLASS_W(CLASS_W), .CLASS_VAL(CLASS_VAL)) u_pack (
    .hit        (enc_hit),
    .verdict    (level_verdict),
    .outcome    (outcome),
    .no_match   (no_match),
    .trap_class (trap_class)
  );

endmodule

// File: rtl/rdprio_trap_chk.sv
module rdprio_trap_chk
  import rdprio_pkg::*;
#(
  parameter int unsigned EL_W    = 2,
  parameter int unsigned CLASS_W = 6
) (
  input logic [EL_W-1:0]    cur_el,
  input logic               sysreg_en_el1,
  input logic               sysreg_en_el2,
  input logic               sysreg_en_el3,
  input logic               mon_irq_route,
  input logic               mon_fiq_route,
  input logic [OC_N-1:0]    outcome,
  input logic               no_match,
  input logic [CLASS_W-1:0] trap_class
);

  always_comb begin
    if (no_match) begin
      AST_QUIET_ON_MISS: assert (outcome == '0 && trap_class == '0); // R1
    end else begin
      AST_ONE_OUTCOME: assert ($countones(outcome) == 1); // R2
      if (cur_el == EL_W'(0)) begin
        AST_EL0_UNDEF: assert (outcome[OC_UNDEF]); // R3
      end
      if (cur_el == EL_W'(1) && !sysreg_en_el1) begin
        AST_EL1_DISABLED: assert (outcome[OC_TRAP1]); // R4
      end
      if (cur_el == EL_W'(2) && sysreg_en_el2 && !(mon_irq_route && mon_fiq_route)) begin
        AST_EL2_SINGLE_ROUTE: assert (outcome[OC_PHYS]); // R8
      end
      if (cur_el == EL_W'(3)) begin
        AST_EL3_CHAIN: assert (outcome[OC_TRAP3] == !sysreg_en_el3 && outcome[OC_PHYS] == sysreg_en_el3); // R7
      end
    end
    AST_CLASS_TRACKS_TRAP: assert ((trap_class != '0) == (|(outcome & OC_TRAP_MASK))); // R9
  end

endmodule

bind sysreg_rdprio_trap_dec rdprio_trap_chk #(.EL_W(EL_W), .CLASS_W(CLASS_W)) chk_i (
  .cur_el        (cur_el),
  .sysreg_en_el1 (sysreg_en_el1),
  .sysreg_en_el2 (sysreg_en_el2),
  .sysreg_en_el3 (sysreg_en_el3),
  .mon_irq_route (mon_irq_route),
  .mon_fiq_route (mon_fiq_route),
  .outcome       (outcome),
  .no_match      (no_match),
  .trap_class    (trap_class)
);

// File: tb/sysreg_rdprio_trap_dec_tb_top.sv
module sysreg_rdprio_trap_dec_tb_top;

  logic clk;
  logic rst_n;
  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] enc_op0;
  logic [2:0] enc_op1;
  logic [3:0] enc_crn;
  logic [3:0] enc_crm;
  logic [2:0] enc_op2;
  logic [1:0] cur_el;
  logic [11:0] cfg;
  logic [5:0] outcome;
  logic       no_match;
  logic [5:0] trap_class;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // cfg bit order (bench only): 0 en1, 1 en2, 2 en3, 3 el2_enabled, 4 el2_is64,
  // 5 el3_present, 6 el3_is64, 7 hyp_trap_common, 8 hyp_fiq, 9 hyp_irq, 10 mon_irq, 11 mon_fiq
  sysreg_rdprio_trap_dec dut_i (
    .enc_op0(enc_op0), .enc_op1(enc_op1), .enc_crn(enc_crn), .enc_crm(enc_crm),
    .enc_op2(enc_op2), .cur_el(cur_el),
    .sysreg_en_el1(cfg[0]), .sysreg_en_el2(cfg[1]), .sysreg_en_el3(cfg[2]),
    .el2_enabled(cfg[3]), .el2_is64(cfg[4]), .el3_present(cfg[5]), .el3_is64(cfg[6]),
    .hyp_trap_common(cfg[7]), .hyp_fiq_route(cfg[8]), .hyp_irq_route(cfg[9]),
    .mon_irq_route(cfg[10]), .mon_fiq_route(cfg[11]),
    .outcome(outcome), .no_match(no_match), .trap_class(trap_class)
  );

  // Expected outcome from the requirements: bit 0 undef, 1..3 trap to EL1..EL3, 4 virtual, 5 physical.
  function automatic logic [5:0] ref_outcome(input logic [1:0] el, input logic [11:0] c);
    logic live2 = c[3] && c[4];
    logic monb  = c[5] && c[6] && c[10] && c[11];
    if (el == 2'd0) return 6'b000001;
    if (el == 2'd3) return c[2] ? 6'b100000 : 6'b001000;
    if (el == 2'd2) begin
      if (!c[1]) return 6'b000100;
      return monb ? 6'b001000 : 6'b100000;
    end
    if (!c[0]) return 6'b000010;
    if (live2 && c[7]) return 6'b000100;
    if (live2 && (c[8] || c[9])) return 6'b010000;
    if (monb) return 6'b001000;
    return 6'b100000;
  endfunction

  task automatic set_match();
    enc_op0 = 2'b11; enc_op1 = 3'b000; enc_crn = 4'b1100; enc_crm = 4'b1011; enc_op2 = 3'b011;
  endtask

  task automatic apply(input logic [1:0] el, input logic [11:0] c);
    @(posedge clk);
    #1;
    cur_el = el;
    cfg = c;
    @(negedge clk);
  endtask

  task automatic expect_hit(input string req, input logic [5:0] exp_oc);
    logic [5:0] exp_cls = (exp_oc[3:1] != 3'b000) ? 6'h18 : 6'h00;
    checks++;
    if (outcome !== exp_oc || no_match !== 1'b0) begin
      failures++;
      $display("FAIL %s el=%0d cfg=%03h outcome actual=%b expected=%b no_match actual=%b expected=0",
               req, cur_el, cfg, outcome, exp_oc, no_match);
    end
    checks++;
    if (trap_class !== exp_cls) begin
      failures++;
      $display("FAIL R9 el=%0d cfg=%03h trap_class actual=%h expected=%h",
               cur_el, cfg, trap_class, exp_cls);
    end
  endtask

  task automatic expect_miss(input string req);
    checks++;
    if (no_match !== 1'b1 || outcome !== 6'b0 || trap_class !== 6'b0) begin
      failures++;
      $display("FAIL %s enc=%b_%b_%b_%b_%b actual no_match=%b outcome=%b class=%h expected 1/000000/00",
               req, enc_op0, enc_op1, enc_crn, enc_crm, enc_op2, no_match, outcome, trap_class);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    enc_op0 = '0; enc_op1 = '0; enc_crn = '0; enc_crm = '0; enc_op2 = '0;
    cur_el = 2'd1; cfg = 12'hfff;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_miss("R1 idle");

    // Exhaustive sweep, matching encoding. R2 one-hot is covered by exact compare.
    set_match();
    for (int el = 0; el < 4; el++) begin
      for (int c = 0; c < 4096; c++) begin
        apply(2'(el), 12'(c));
        case (el)
          0: expect_hit("R3", ref_outcome(2'(el), 12'(c)));
          1: expect_hit("R4", ref_outcome(2'(el), 12'(c)));
          2: expect_hit("R6", ref_outcome(2'(el), 12'(c)));
          default: expect_hit("R7", ref_outcome(2'(el), 12'(c)));
        endcase
      end
    end

    // R5: route bits without a live EL2 have no effect at EL1.
    apply(2'd1, 12'b0011_0000_0001); expect_hit("R5", 6'b100000);
    apply(2'd1, 12'b0011_0000_1001); expect_hit("R5", 6'b100000);
    apply(2'd1, 12'b0001_0001_1001); expect_hit("R5", 6'b010000);

    // R8: one monitor route bit alone never traps to EL3.
    apply(2'd2, 12'b0100_0110_0111); expect_hit("R8", 6'b100000);
    apply(2'd2, 12'b1000_0110_0111); expect_hit("R8", 6'b100000);
    apply(2'd2, 12'b1100_0110_0111); expect_hit("R8", 6'b001000);
    apply(2'd1, 12'b0100_0110_0111); expect_hit("R8", 6'b100000);

    // R1: every single-bit flip of the encoding and a few near misses.
    cfg = 12'hfff;
    for (int b = 0; b < 15; b++) begin
      logic [14:0] e;
      @(posedge clk);
      #1;
      e = {2'b11, 3'b000, 4'b1100, 4'b1011, 3'b011} ^ (15'd1 << b);
      {enc_op0, enc_op1, enc_crn, enc_crm, enc_op2} = e;
      cur_el = 2'(b % 4);
      @(negedge clk);
      expect_miss("R1");
    end
    @(posedge clk); #1; set_match(); enc_crm = 4'b1010; @(negedge clk); expect_miss("R1");
    @(posedge clk); #1; set_match(); enc_crn = 4'b1011; @(negedge clk); expect_miss("R1");
    @(posedge clk); #1; set_match(); enc_op2 = 3'b100; @(negedge clk); expect_miss("R1");
    @(posedge clk); #1; set_match(); @(negedge clk); expect_hit("R1", ref_outcome(cur_el, cfg));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule